// File: doc/BRIEF.md
# Random-Access Configuration Bus Interface

This block is the host-side port of a reconfigurable cell array. A processor sees the whole array as ordinary memory. It has a 16-bit address, a chip select and a single read/write line. A configuration word, a column of user register cells or one of four control registers can be read or written at any address in any order. A partial reconfiguration therefore touches only the words that change. The active data lanes can be set to 8, 16 or 32 bits.

Two control registers make bulk and scattered access cheap. The row map names the cells of a column that form one user register. Their bits move to and from consecutive data bits starting at bit 0, so the host never shifts or masks. Two don't-care masks, one for configuration addresses and one for column addresses, turn a single write cycle into a broadcast to every matching location. The cell array is modelled as plain registers.

Top module: `cfgbus_port`

## Requirements
- R1: Reset (synchronous, active low) clears read data, every configuration word, every user cell, the row map and both don't-care masks, and sets the lane width code to 2 (32 bits).
- R2: A write (`rd_wr`=0) takes effect on the rising clock edge where `cs` is high. With `cs` low nothing changes, and a read (`rd_wr`=1) never changes stored state.
- R3: Read data appears on `rdata` one cycle after a read is presented and holds its value until the next read.
- R4: Lane width code (control register 0, bits 1:0) is 00 for 8 bits, 01 for 16 bits and 1x for 32 bits. On a read, data bits at and above the lane width are zero.
- R5: A configuration write changes only the bits of the word below the lane width. The upper bits keep their old value.
- R6: A user register read returns the cells of the addressed column whose row-map bit is 1, in ascending row order, packed into data bits 0 upward.
- R7: A row map of zero selects all cells of the column.
- R8: A user register write loads the selected cells in ascending row order from consecutive data bits starting at bit 0. Selected cells beyond the lane width and unselected cells keep their values.
- R9: A configuration write stores the data in every word whose index equals the address on all bits not set in the configuration don't-care mask (control register 2).
- R10: A user register write applies to every column whose index equals the address on all bits not set in the column don't-care mask (control register 3).
- R11: A read ignores masked address bits and returns the location at the address with those bits cleared, which is the lowest matching location.
- R12: The address map is as follows. Bits 15:14 give the region: 00 configuration (word index in bits 5:0), 01 user columns (column in bits 3:0), 10 control (register in bits 1:0: width, row map, configuration mask, column mask), 11 unused. Unused address bits inside a region must be zero, or the access hits nothing and reads return zero. Control registers are written at full width and read back.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs | input | 1 | Chip select, access when high |
| rd_wr | input | 1 | 1 = read, 0 = write |
| addr | input | 16 | Host address |
| wdata | input | 32 | Host write data |
| rdata | output | 32 | Registered read data |

## Verification
The bench first sets one of the don't-care masks and writes once. It then clears the mask and reads each matching location and one neighbour outside the match. A decoder that ignored the mask would leave three locations stale, and one that over-matched would corrupt the neighbour. It programs a sparse row map spread over the column and checks both the packed read and the unpacked write. An off-by-one in the running cell count would move bits or overwrite unselected cells. It changes lane width between writes and reads to catch upper bits that leak out or get overwritten. It also reads with the mask set, which exposes a design that does not clear the masked bits. Accesses with stray middle address bits, the unused region, idle cycles with chip select low and a mid-run reset complete the set.

// File: rtl/cfgbus_pkg.sv
// Shared types and helpers for the configuration bus port.
// Assumes a fixed 32-bit host data bus; lane width is a 2-bit code.
package cfgbus_pkg;

    localparam int DATA_W = 32;
    localparam int ADDR_W = 16;

    typedef enum logic [1:0] {
        RG_CFG  = 2'b00,
        RG_USER = 2'b01,
        RG_CTL  = 2'b10,
        RG_NONE = 2'b11
    } region_e;

    typedef enum logic [1:0] {
        CT_WIDTH = 2'b00,
        CT_MAP   = 2'b01,
        CT_WCFG  = 2'b10,
        CT_WCOL  = 2'b11
    } ctl_e;

    // Data lanes enabled by a width code.
    function automatic logic [DATA_W-1:0] lane_mask(input logic [1:0] code);
        case (code)
            2'b00:   return 32'h0000_00FF;
            2'b01:   return 32'h0000_FFFF;
            default: return 32'hFFFF_FFFF;
        endcase
    endfunction

    // Number of enabled data lanes for a width code.
    function automatic logic [6:0] lane_bits(input logic [1:0] code);
        case (code)
            2'b00:   return 7'd8;
            2'b01:   return 7'd16;
            default: return 7'd32;
        endcase
    endfunction

endpackage

// File: rtl/cfgbus_decode.sv
// Address decoder: splits the host address into region, word index,
// column index and control register, and expands write strobes through
// the don't-care masks into one strobe per location.
// Assumes CFG_AW and COL_AW are below 14 and that masks apply to writes;
// read indices are the address with masked bits cleared.
module cfgbus_decode
    import cfgbus_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int COL_AW = 4,
    localparam int CFG_WORDS = 1 << CFG_AW,
    localparam int COLS = 1 << COL_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 cs,
    input  logic                 rd_wr,
    input  logic [ADDR_W-1:0]    addr,
    input  logic [CFG_AW-1:0]    cfg_wild,
    input  logic [COL_AW-1:0]    col_wild,
    output logic [CFG_WORDS-1:0] cfg_we,
    output logic [COLS-1:0]      col_we,
    output logic                 ctl_we,
    output ctl_e                 ctl_reg,
    output logic                 rd_en,
    output region_e              rd_region,
    output logic [CFG_AW-1:0]    cfg_rd_idx,
    output logic [COL_AW-1:0]    col_rd_idx
);

    logic    wr_en;
    region_e region;
    logic    cfg_ok, col_ok, ctl_ok;

    // Region and in-region validity of the current address.
    always_comb begin
        wr_en  = cs & ~rd_wr;
        rd_en  = cs & rd_wr;
        region = region_e'(addr[15:14]);
        cfg_ok = (region == RG_CFG)  && (addr[13:CFG_AW] == '0);
        col_ok = (region == RG_USER) && (addr[13:COL_AW] == '0);
        ctl_ok = (region == RG_CTL)  && (addr[13:2] == '0);
    end

    // Read-side selection and control strobe.
    always_comb begin
        if (cfg_ok)      rd_region = RG_CFG;
        else if (col_ok) rd_region = RG_USER;
        else if (ctl_ok) rd_region = RG_CTL;
        else             rd_region = RG_NONE;
        ctl_we     = wr_en & ctl_ok;
        ctl_reg    = ctl_e'(addr[1:0]);
        cfg_rd_idx = addr[CFG_AW-1:0] & ~cfg_wild;
        col_rd_idx = addr[COL_AW-1:0] & ~col_wild;
    end

    // One masked compare per configuration word.
    for (genvar i = 0; i < CFG_WORDS; i++) begin : g_cfg_hit
        localparam logic [CFG_AW-1:0] IDX = CFG_AW'(i);
        assign cfg_we[i] = wr_en & cfg_ok &
                           (((IDX ^ addr[CFG_AW-1:0]) & ~cfg_wild) == '0);
    end

    // One masked compare per user column.
    for (genvar c = 0; c < COLS; c++) begin : g_col_hit
        localparam logic [COL_AW-1:0] IDX = COL_AW'(c);
        assign col_we[c] = wr_en & col_ok &
                           (((IDX ^ addr[COL_AW-1:0]) & ~col_wild) == '0);
    end

    // R9: broadcast reaches exactly 2^(masked bits) words
    p_cfg_fanout_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cfg_ok) |->
            ($countones(cfg_we) == (1 << $countones(cfg_wild))))
        else $error("cfg broadcast fan-out wrong");

    // R10: column broadcast reaches exactly 2^(masked bits) columns
    p_col_fanout_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && col_ok) |->
            ($countones(col_we) == (1 << $countones(col_wild))))
        else $error("column broadcast fan-out wrong");

    // R2: no strobe without a selected write
    p_no_stray_we_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(cs && !rd_wr) |-> (cfg_we == '0 && col_we == '0 && !ctl_we))
        else $error("write strobe without write");

endmodule

// File: rtl/cfgbus_cfg_mem.sv
// Configuration memory: one register word per location, written under a
// per-word strobe with a lane mask so narrow writes keep upper bits.
// Assumes strobes come pre-expanded from the decoder.
module cfgbus_cfg_mem
    import cfgbus_pkg::*;
#(
    parameter int CFG_AW = 6,
    localparam int CFG_WORDS = 1 << CFG_AW
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [CFG_WORDS-1:0] we,
    input  logic [DATA_W-1:0]    wdata,
    input  logic [DATA_W-1:0]    lanes,
    input  logic [CFG_AW-1:0]    rd_idx,
    output logic [DATA_W-1:0]    rd_word
);

    logic [DATA_W-1:0] mem [CFG_WORDS];

    for (genvar i = 0; i < CFG_WORDS; i++) begin : g_word
        // Merge enabled lanes of write data into the stored word.
        always_ff @(posedge clk) begin
            if (!rst_n)    mem[i] <= '0;
            else if (we[i]) mem[i] <= (mem[i] & ~lanes) | (wdata & lanes);
        end

        // R2: words without a strobe keep their value
        p_word_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
            !we[i] |=> $stable(mem[i]))
            else $error("cfg word changed without strobe");

        // R5: bits outside the enabled lanes survive a write
        p_upper_keep_r5: assert property (@(posedge clk) disable iff (!rst_n)
            we[i] |=> ((mem[i] & ~$past(lanes)) == ($past(mem[i]) & ~$past(lanes))))
            else $error("cfg write touched disabled lanes");
    end

    // Read port at the decoded index.
    always_comb rd_word = mem[rd_idx];

endmodule

// File: rtl/cfgbus_user_cells.sv
// User register cells: COLS columns of ROWS one-bit cells. A row select
// picks the cells that form the register; write data is unpacked to them
// from bit 0 upward and read data is packed the same way.
// Assumes ROWS is at most the 32-bit data width.
module cfgbus_user_cells
    import cfgbus_pkg::*;
#(
    parameter int COL_AW = 4,
    parameter int ROWS = 32,
    localparam int COLS = 1 << COL_AW
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [COLS-1:0]   we,
    input  logic [DATA_W-1:0] wdata,
    input  logic [ROWS-1:0]   sel,
    input  logic [6:0]        nbits,
    input  logic [COL_AW-1:0] rd_idx,
    output logic [DATA_W-1:0] rd_word
);

    logic [ROWS-1:0] cells [COLS];
    logic [ROWS-1:0] upd;
    logic [ROWS-1:0] val;
    logic [ROWS-1:0] rd_col;

    // Unpack: the k-th selected row takes data bit k if k is inside the lanes.
    always_comb begin
        logic [6:0] k;
        k   = '0;
        upd = '0;
        val = '0;
        for (int r = 0; r < ROWS; r++) begin
            if (sel[r]) begin
                if (k < nbits) begin
                    upd[r] = 1'b1;
                    val[r] = wdata[k[4:0]];
                end
                k = k + 7'd1;
            end
        end
    end

    for (genvar c = 0; c < COLS; c++) begin : g_col
        // Update the chosen cells of a strobed column.
        always_ff @(posedge clk) begin
            if (!rst_n)     cells[c] <= '0;
            else if (we[c]) cells[c] <= (cells[c] & ~upd) | (val & upd);
        end

        // R8: a column without a strobe keeps every cell
        p_col_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
            !we[c] |=> $stable(cells[c]))
            else $error("column changed without strobe");

        // R8: unselected cells never change
        p_unsel_keep_r8: assert property (@(posedge clk) disable iff (!rst_n)
            we[c] |=> ((cells[c] & ~$past(sel)) == ($past(cells[c]) & ~$past(sel))))
            else $error("unselected cell written");
    end

    // Pack: selected cells of the read column go to consecutive low bits.
    always_comb begin
        logic [6:0] k;
        k       = '0;
        rd_word = '0;
        rd_col  = cells[rd_idx];
        for (int r = 0; r < ROWS; r++) begin
            if (sel[r]) begin
                rd_word[k[4:0]] = rd_col[r];
                k = k + 7'd1;
            end
        end
    end

    // R8: never more cells updated than lanes available
    p_upd_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
        ($countones(upd) <= int'(nbits)))
        else $error("more cells updated than lanes");

endmodule

// File: rtl/cfgbus_port.sv
// Host port of the cell array: decodes the address, holds the control
// registers (lane width, row map, two don't-care masks), drives the
// configuration memory and user cells, and registers read data.
// Assumes one access per cycle; read data is valid the cycle after.
module cfgbus_port
    import cfgbus_pkg::*;
#(
    parameter int CFG_AW = 6,
    parameter int COL_AW = 4,
    parameter int ROWS = 32
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs,
    input  logic        rd_wr,
    input  logic [15:0] addr,
    input  logic [31:0] wdata,
    output logic [31:0] rdata
);

    localparam int CFG_WORDS = 1 << CFG_AW;
    localparam int COLS = 1 << COL_AW;

    logic [1:0]        width_q;
    logic [ROWS-1:0]   map_q;
    logic [CFG_AW-1:0] wcfg_q;
    logic [COL_AW-1:0] wcol_q;

    logic [CFG_WORDS-1:0] cfg_we;
    logic [COLS-1:0]      col_we;
    logic                 ctl_we;
    ctl_e                 ctl_reg;
    logic                 rd_en;
    region_e              rd_region;
    logic [CFG_AW-1:0]    cfg_rd_idx;
    logic [COL_AW-1:0]    col_rd_idx;

    logic [DATA_W-1:0] lanes;
    logic [6:0]        nbits;
    logic [ROWS-1:0]   row_sel;
    logic [DATA_W-1:0] cfg_word, user_word, ctl_word, rd_mux;
    logic [DATA_W-1:0] rdata_q;

    cfgbus_decode #(.CFG_AW(CFG_AW), .COL_AW(COL_AW)) i_decode (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd_wr(rd_wr), .addr(addr),
        .cfg_wild(wcfg_q), .col_wild(wcol_q),
        .cfg_we(cfg_we), .col_we(col_we), .ctl_we(ctl_we), .ctl_reg(ctl_reg),
        .rd_en(rd_en), .rd_region(rd_region),
        .cfg_rd_idx(cfg_rd_idx), .col_rd_idx(col_rd_idx)
    );

    // Lane controls and effective row select (zero map means all rows).
    always_comb begin
        lanes   = lane_mask(width_q);
        nbits   = lane_bits(width_q);
        row_sel = (map_q == '0) ? '1 : map_q;
    end

    cfgbus_cfg_mem #(.CFG_AW(CFG_AW)) i_cfg_mem (
        .clk(clk), .rst_n(rst_n), .we(cfg_we), .wdata(wdata),
        .lanes(lanes), .rd_idx(cfg_rd_idx), .rd_word(cfg_word)
    );

    cfgbus_user_cells #(.COL_AW(COL_AW), .ROWS(ROWS)) i_cells (
        .clk(clk), .rst_n(rst_n), .we(col_we), .wdata(wdata),
        .sel(row_sel), .nbits(nbits), .rd_idx(col_rd_idx), .rd_word(user_word)
    );

    // Control registers, always written at full width.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            width_q <= 2'b10;
            map_q   <= '0;
            wcfg_q  <= '0;
            wcol_q  <= '0;
        end else if (ctl_we) begin
            case (ctl_reg)
                CT_WIDTH: width_q <= wdata[1:0];
                CT_MAP:   map_q   <= wdata[ROWS-1:0];
                CT_WCFG:  wcfg_q  <= wdata[CFG_AW-1:0];
                CT_WCOL:  wcol_q  <= wdata[COL_AW-1:0];
                default:  ;
            endcase
        end
    end

    // Control register read-back.
    always_comb begin
        case (ctl_reg)
            CT_WIDTH: ctl_word = DATA_W'(width_q);
            CT_MAP:   ctl_word = DATA_W'(map_q);
            CT_WCFG:  ctl_word = DATA_W'(wcfg_q);
            default:  ctl_word = DATA_W'(wcol_q);
        endcase
    end

    // Read source by region, limited to the enabled lanes.
    always_comb begin
        case (rd_region)
            RG_CFG:  rd_mux = cfg_word;
            RG_USER: rd_mux = user_word;
            RG_CTL:  rd_mux = ctl_word;
            default: rd_mux = '0;
        endcase
        rd_mux = rd_mux & lanes;
    end

    // Read data register, loaded only by a read.
    always_ff @(posedge clk) begin
        if (!rst_n)     rdata_q <= '0;
        else if (rd_en) rdata_q <= rd_mux;
    end

    assign rdata = rdata_q;

    // R4: read data never carries bits above the lane width in force at the read
    p_rd_lanes_r4: assert property (@(posedge clk) disable iff (!rst_n)
        $past(rd_en) |-> ((rdata & ~lane_mask($past(width_q))) == '0))
        else $error("read data above lane width");

    // R3: read data holds between reads
    p_rd_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_en |=> $stable(rdata))
        else $error("read data changed without read");

    // R1: leaving reset, control registers are at their defaults
    p_reset_ctl_r1: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (map_q == '0 && wcfg_q == '0 && wcol_q == '0 &&
                          width_q == 2'b10 && rdata == '0))
        else $error("control state not reset");

endmodule

// File: tb/test_cfgbus_port.sv
`timescale 1ns/1ps
module test_cfgbus_port;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cs = 1'b0;
    logic        rd_wr = 1'b0;
    logic [15:0] addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk;   // 125 MHz

    cfgbus_port i_cfgbus_port (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd_wr(rd_wr),
        .addr(addr), .wdata(wdata), .rdata(rdata)
    );

    // Vector: {is_read, addr, data-or-expected, requirement number}
    localparam int NV = 56;
    localparam logic [80:0] VEC [NV] = '{
        {1'b0, 16'h0005, 32'hDEADBEEF, 32'd2},   // R2 plain write
        {1'b1, 16'h0005, 32'hDEADBEEF, 32'd3},   // R3 read back
        {1'b0, 16'h0006, 32'h12345678, 32'd2},
        {1'b1, 16'h0006, 32'h12345678, 32'd3},
        {1'b1, 16'h0005, 32'hDEADBEEF, 32'd2},   // R2 neighbour untouched
        {1'b0, 16'h8000, 32'h00000000, 32'd4},   // R4 width 8
        {1'b1, 16'h0005, 32'h000000EF, 32'd4},
        {1'b0, 16'h0005, 32'hFFFFFF11, 32'd5},   // R5 narrow write
        {1'b0, 16'h8000, 32'h00000002, 32'd5},
        {1'b1, 16'h0005, 32'hDEADBE11, 32'd5},
        {1'b0, 16'h8000, 32'h00000001, 32'd4},   // R4 width 16
        {1'b1, 16'h0006, 32'h00005678, 32'd4},
        {1'b1, 16'h8000, 32'h00000001, 32'd12},  // R12 width read-back
        {1'b0, 16'h8000, 32'h00000002, 32'd4},
        {1'b0, 16'h4003, 32'hA5A5F00F, 32'd7},   // R7 all rows
        {1'b1, 16'h4003, 32'hA5A5F00F, 32'd7},
        {1'b0, 16'h8001, 32'h80020011, 32'd6},   // R6 rows 0,4,17,31
        {1'b1, 16'h8001, 32'h80020011, 32'd12},
        {1'b1, 16'h4003, 32'h00000009, 32'd6},
        {1'b0, 16'h4003, 32'hFFFFFFF6, 32'd8},   // R8 scattered write
        {1'b1, 16'h4003, 32'h00000006, 32'd8},
        {1'b0, 16'h8001, 32'h00000000, 32'd7},
        {1'b1, 16'h4003, 32'h25A7F01E, 32'd8},
        {1'b0, 16'h8000, 32'h00000000, 32'd8},   // R8 width limits cells
        {1'b0, 16'h4003, 32'h000000C3, 32'd8},
        {1'b0, 16'h8000, 32'h00000002, 32'd8},
        {1'b1, 16'h4003, 32'h25A7F0C3, 32'd8},
        {1'b0, 16'h8002, 32'h00000003, 32'd9},   // R9 mask bits 1:0
        {1'b0, 16'h0010, 32'h0BADF00D, 32'd9},
        {1'b0, 16'h8002, 32'h00000000, 32'd9},
        {1'b1, 16'h0010, 32'h0BADF00D, 32'd9},
        {1'b1, 16'h0011, 32'h0BADF00D, 32'd9},
        {1'b1, 16'h0012, 32'h0BADF00D, 32'd9},
        {1'b1, 16'h0013, 32'h0BADF00D, 32'd9},
        {1'b1, 16'h0014, 32'h00000000, 32'd9},
        {1'b0, 16'h0011, 32'h11111111, 32'd11},  // R11 lowest match on read
        {1'b0, 16'h8002, 32'h00000003, 32'd11},
        {1'b1, 16'h0013, 32'h0BADF00D, 32'd11},
        {1'b1, 16'h8002, 32'h00000003, 32'd12},
        {1'b0, 16'h8002, 32'h00000000, 32'd11},
        {1'b1, 16'h0011, 32'h11111111, 32'd11},
        {1'b0, 16'h8003, 32'h00000008, 32'd10},  // R10 column mask bit 3
        {1'b0, 16'h4001, 32'h13579BDF, 32'd10},
        {1'b1, 16'h8003, 32'h00000008, 32'd12},
        {1'b0, 16'h8003, 32'h00000000, 32'd10},
        {1'b1, 16'h4001, 32'h13579BDF, 32'd10},
        {1'b1, 16'h4009, 32'h13579BDF, 32'd10},
        {1'b1, 16'h4003, 32'h25A7F0C3, 32'd10},
        {1'b1, 16'h4002, 32'h00000000, 32'd10},
        {1'b1, 16'hC000, 32'h00000000, 32'd12},  // R12 unused region
        {1'b0, 16'hC005, 32'hFFFFFFFF, 32'd12},
        {1'b1, 16'h0005, 32'hDEADBE11, 32'd12},
        {1'b0, 16'h0045, 32'hFFFFFFFF, 32'd12},  // R12 stray middle bit
        {1'b1, 16'h0005, 32'hDEADBE11, 32'd12},
        {1'b1, 16'h0045, 32'h00000000, 32'd12},
        {1'b1, 16'h8000, 32'h00000002, 32'd12}
    };

    task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            errors++;
            $display("FAIL %s got %08h expected %08h", req, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; rd_wr = 1'b0; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, output logic [31:0] d);
        @(negedge clk);
        cs = 1'b1; rd_wr = 1'b1; addr = a;
        @(negedge clk);
        cs = 1'b0;
        d = rdata;
    endtask

    task automatic finish_run();
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    initial begin
        #1_000_000;
        checks++; errors++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        logic [31:0] d;
        repeat (3) @(negedge clk);
        check("R1 rdata reset", rdata, 32'h0);
        rst_n = 1'b1;
        do_read(16'h8000, d); check("R1 width reset", d, 32'h2);
        do_read(16'h8001, d); check("R1 map reset", d, 32'h0);
        do_read(16'h8002, d); check("R1 cfg mask reset", d, 32'h0);
        do_read(16'h8003, d); check("R1 col mask reset", d, 32'h0);
        do_read(16'h0005, d); check("R1 cfg word reset", d, 32'h0);

        for (int i = 0; i < NV; i++) begin
            if (VEC[i][80]) begin
                do_read(VEC[i][79:64], d);
                check($sformatf("R%0d vector %0d", VEC[i][31:0], i), d, VEC[i][63:32]);
            end else begin
                do_write(VEC[i][79:64], VEC[i][63:32]);
            end
        end

        // R2: a write with chip select low is ignored
        @(negedge clk);
        cs = 1'b0; rd_wr = 1'b0; addr = 16'h0005; wdata = 32'h0;
        @(negedge clk);
        do_read(16'h0005, d); check("R2 cs low", d, 32'hDEADBE11);

        // R3: read data holds through idle cycles and writes
        repeat (2) @(negedge clk);
        check("R3 hold idle", rdata, 32'hDEADBE11);
        do_write(16'h0006, 32'h0);
        check("R3 hold over write", rdata, 32'hDEADBE11);

        // R3: one-cycle latency on a changed address
        @(negedge clk);
        cs = 1'b1; rd_wr = 1'b1; addr = 16'h0006;
        @(negedge clk);
        check("R3 latency", rdata, 32'h0);
        addr = 16'h0005;
        @(negedge clk);
        cs = 1'b0;
        check("R3 back-to-back", rdata, 32'hDEADBE11);

        // R1: reset in mid-run restores defaults
        do_write(16'h8001, 32'h0000000F);
        do_write(16'h8000, 32'h0);
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1;
        check("R1 rdata after reset", rdata, 32'h0);
        do_read(16'h8001, d); check("R1 map after reset", d, 32'h0);
        do_read(16'h8000, d); check("R1 width after reset", d, 32'h2);
        do_read(16'h0005, d); check("R1 cfg after reset", d, 32'h0);
        do_read(16'h4003, d); check("R1 cells after reset", d, 32'h0);

        finish_run();
    end

endmodule